// File: doc/BRIEF.md
# Fast System Call Privilege Transition Unit

This block computes the architectural state change for a fast kernel-entry operation and its matching kernel-exit operation in a 32-bit protected-mode core. It holds three model-specific registers: a base code selector, a kernel instruction pointer and a kernel stack pointer. Software loads them through a small indexed write port.

When an entry or exit request arrives, the unit checks the preconditions. If they hold, one cycle later it presents the new instruction pointer, stack pointer, code and stack selectors, flat descriptor-cache values and privilege level, together with a one-cycle `done` pulse. An entry also pulses the flag-clear strobes. If a precondition fails, the unit pulses `fault` for one cycle instead and leaves every state output as it was. The segment state is derived only from the selector register using fixed arithmetic, and no descriptor table is read.

Top module: `fastcall_xfer_unit`

## Requirements
- R1: Reset clears all three model-specific registers and every state output, with `done`, `fault`, `clr_vm` and `clr_if` low. A request made straight after reset faults because the selector register is zero.
- R2: A write with `msr_we` high stores `msr_wdata` by index: 0 is the selector (low 16 bits kept), 1 is the kernel instruction pointer, 2 is the kernel stack pointer. A write to index 3 changes nothing.
- R3: Either request faults if `feat_en` is low, if `prot_mode` is low, or if the selector register is zero.
- R4: An exit request also faults unless `cur_cpl` is 0.
- R5: Entry and exit requested in the same cycle fault.
- R6: A successful entry loads the instruction pointer and stack pointer from registers 1 and 2, and pulses `clr_vm` and `clr_if` together with `done`.
- R7: On entry, the code selector is the selector register with bits 1:0 cleared, and the stack selector is the code selector plus 8, modulo 2^16.
- R8: On exit, the instruction pointer is taken from `gpr_edx` and the stack pointer from `gpr_ecx`. The code selector is the selector register with bits 1:0 set, and the stack selector is that value plus 8, modulo 2^16.
- R9: After any successful request the descriptor outputs show base 0, limit 0xFFFFFFFF, expand-down clear and 32-bit default size set.
- R10: The privilege level output becomes 0 after an entry and 3 after an exit.
- R11: `done` or `fault` is high for exactly one cycle, in the cycle after a one-cycle request, and never both together. On a fault all state outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Fast call feature enable |
| prot_mode | input | 1 | Processor is in protected mode |
| cur_cpl | input | 2 | Current privilege level |
| msr_we | input | 1 | Register write enable |
| msr_idx | input | 2 | Register index |
| msr_wdata | input | 32 | Register write data |
| req_enter | input | 1 | Kernel entry request |
| req_exit | input | 1 | Kernel exit request |
| gpr_edx | input | 32 | EDX value (exit target IP) |
| gpr_ecx | input | 32 | ECX value (exit target SP) |
| done | output | 1 | Successful transition pulse |
| fault | output | 1 | Rejected request pulse |
| new_eip | output | 32 | New instruction pointer |
| new_esp | output | 32 | New stack pointer |
| new_cs | output | 16 | New code selector |
| new_ss | output | 16 | New stack selector |
| seg_base | output | 32 | Code/stack descriptor base |
| seg_limit | output | 32 | Code/stack descriptor limit |
| seg_expdn | output | 1 | Expand-down attribute |
| seg_big | output | 1 | 32-bit default size attribute |
| new_cpl | output | 2 | New privilege level |
| clr_vm | output | 1 | Clear VM flag strobe |
| clr_if | output | 1 | Clear IF flag strobe |

## Verification
The case hardest to reach from the ports is a selector near the top of its range, where adding 8 for the stack selector has to wrap modulo 2^16. The bench programs 0xFFFC and runs both an entry and an exit, which gives stack selectors 0x0004 and 0x0007. A second subtle case is a fault arriving right after a success. Here the state outputs must keep the earlier values, so the bench places rejected requests (CPL 3 exit, simultaneous requests) directly after successful ones and compares every field against the remembered state.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;
  typedef enum logic [1:0] {
    MSR_SEL   = 2'd0,
    MSR_KIP   = 2'd1,
    MSR_KSP   = 2'd2,
    MSR_SPARE = 2'd3
  } msr_idx_e;

  localparam logic [1:0] PL_KERNEL = 2'd0;
  localparam logic [1:0] PL_USER   = 2'd3;
endpackage

// File: rtl/fastcall_msr_bank.sv
module fastcall_msr_bank #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       idx,
  input  logic [XLEN-1:0]  wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic [XLEN-1:0]  kip_q,
  output logic [XLEN-1:0]  ksp_q
);
  import fastcall_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      kip_q <= '0;
      ksp_q <= '0;
    end else if (we) begin
      case (msr_idx_e'(idx))
        MSR_SEL: sel_q <= wdata[SEL_W-1:0];
        MSR_KIP: kip_q <= wdata;
        MSR_KSP: ksp_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fastcall_gate.sv
module fastcall_gate #(
  parameter int unsigned SEL_W = 16
) (
  input  logic             feat_en,
  input  logic             prot_mode,
  input  logic [1:0]       cur_cpl,
  input  logic [SEL_W-1:0] sel,
  input  logic             req_enter,
  input  logic             req_exit,
  output logic             go_enter,
  output logic             go_exit,
  output logic             reject
);
  import fastcall_pkg::*;

  logic base_ok;
  logic single;

  always_comb begin
    base_ok  = feat_en && prot_mode && (sel != '0);
    single   = req_enter ^ req_exit;
    go_enter = req_enter && single && base_ok;
    go_exit  = req_exit && single && base_ok && (cur_cpl == PL_KERNEL);
    reject   = (req_enter || req_exit) && !go_enter && !go_exit;
  end
endmodule

// File: rtl/fastcall_state_gen.sv
module fastcall_state_gen #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned STACK_STEP = 8
) (
  input  logic             to_user,
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  kip,
  input  logic [XLEN-1:0]  ksp,
  input  logic [XLEN-1:0]  edx,
  input  logic [XLEN-1:0]  ecx,
  output logic [XLEN-1:0]  eip_n,
  output logic [XLEN-1:0]  esp_n,
  output logic [SEL_W-1:0] cs_n,
  output logic [SEL_W-1:0] ss_n,
  output logic [1:0]       cpl_n
);
  import fastcall_pkg::*;

  localparam logic [SEL_W-1:0] RPL_MASK = SEL_W'(3);
  localparam logic [SEL_W-1:0] SS_STEP  = SEL_W'(STACK_STEP);

  always_comb begin
    if (to_user) begin
      eip_n = edx;
      esp_n = ecx;
      cs_n  = sel | RPL_MASK;
      cpl_n = PL_USER;
    end else begin
      eip_n = kip;
      esp_n = ksp;
      cs_n  = sel & ~RPL_MASK;
      cpl_n = PL_KERNEL;
    end
    ss_n = cs_n + SS_STEP;
  end
endmodule

// File: rtl/fastcall_xfer_unit.sv
module fastcall_xfer_unit #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned STACK_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feat_en,
  input  logic             prot_mode,
  input  logic [1:0]       cur_cpl,
  input  logic             msr_we,
  input  logic [1:0]       msr_idx,
  input  logic [XLEN-1:0]  msr_wdata,
  input  logic             req_enter,
  input  logic             req_exit,
  input  logic [XLEN-1:0]  gpr_edx,
  input  logic [XLEN-1:0]  gpr_ecx,
  output logic             done,
  output logic             fault,
  output logic [XLEN-1:0]  new_eip,
  output logic [XLEN-1:0]  new_esp,
  output logic [SEL_W-1:0] new_cs,
  output logic [SEL_W-1:0] new_ss,
  output logic [XLEN-1:0]  seg_base,
  output logic [XLEN-1:0]  seg_limit,
  output logic             seg_expdn,
  output logic             seg_big,
  output logic [1:0]       new_cpl,
  output logic             clr_vm,
  output logic             clr_if
);
  logic [SEL_W-1:0] sel_q;
  logic [XLEN-1:0]  kip_q, ksp_q;
  logic             go_enter, go_exit, reject;
  logic [XLEN-1:0]  eip_n, esp_n;
  logic [SEL_W-1:0] cs_n, ss_n;
  logic [1:0]       cpl_n;

  fastcall_msr_bank #(.XLEN(XLEN), .SEL_W(SEL_W)) u_msr (
    .clk(clk), .rst(rst), .we(msr_we), .idx(msr_idx), .wdata(msr_wdata),
    .sel_q(sel_q), .kip_q(kip_q), .ksp_q(ksp_q)
  );

  fastcall_gate #(.SEL_W(SEL_W)) u_gate (
    .feat_en(feat_en), .prot_mode(prot_mode), .cur_cpl(cur_cpl), .sel(sel_q),
    .req_enter(req_enter), .req_exit(req_exit),
    .go_enter(go_enter), .go_exit(go_exit), .reject(reject)
  );

  fastcall_state_gen #(.XLEN(XLEN), .SEL_W(SEL_W), .STACK_STEP(STACK_STEP)) u_gen (
    .to_user(go_exit), .sel(sel_q), .kip(kip_q), .ksp(ksp_q),
    .edx(gpr_edx), .ecx(gpr_ecx),
    .eip_n(eip_n), .esp_n(esp_n), .cs_n(cs_n), .ss_n(ss_n), .cpl_n(cpl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      clr_vm    <= 1'b0;
      clr_if    <= 1'b0;
      new_eip   <= '0;
      new_esp   <= '0;
      new_cs    <= '0;
      new_ss    <= '0;
      seg_base  <= '0;
      seg_limit <= '0;
      seg_expdn <= 1'b0;
      seg_big   <= 1'b0;
      new_cpl   <= '0;
    end else begin
      done   <= go_enter || go_exit;
      fault  <= reject;
      clr_vm <= go_enter;
      clr_if <= go_enter;
      if (go_enter || go_exit) begin
        new_eip   <= eip_n;
        new_esp   <= esp_n;
        new_cs    <= cs_n;
        new_ss    <= ss_n;
        new_cpl   <= cpl_n;
        seg_base  <= '0;
        seg_limit <= '1;
        seg_expdn <= 1'b0;
        seg_big   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fastcall_xfer_chk.sv
module fastcall_xfer_chk #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned STACK_STEP = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cur_cpl,
  input logic             req_enter,
  input logic             req_exit,
  input logic             done,
  input logic             fault,
  input logic [XLEN-1:0]  new_eip,
  input logic [XLEN-1:0]  new_esp,
  input logic [SEL_W-1:0] new_cs,
  input logic [SEL_W-1:0] new_ss,
  input logic [XLEN-1:0]  seg_base,
  input logic [XLEN-1:0]  seg_limit,
  input logic             seg_expdn,
  input logic             seg_big,
  input logic [1:0]       new_cpl,
  input logic             clr_vm,
  input logic             clr_if
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  a_r11_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_enter || req_exit));

  a_r11_fault_cause: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(req_enter || req_exit));

  a_r11_fault_hold: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(new_eip) && $stable(new_esp) && $stable(new_cs)
               && $stable(new_ss) && $stable(new_cpl)));

  a_r5_no_dual: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(req_enter && req_exit));

  a_r4_exit_from_ring0: assert property (@(posedge clk) disable iff (rst)
    (done && new_cpl == 2'd3) |-> $past(cur_cpl) == 2'd0);

  a_r10_pl_values: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_cpl == 2'd0 || new_cpl == 2'd3));

  a_r7_stack_sel: assert property (@(posedge clk) disable iff (rst)
    done |-> new_ss == new_cs + SEL_W'(STACK_STEP));

  a_r9_flat_desc: assert property (@(posedge clk) disable iff (rst)
    done |-> (seg_base == '0 && seg_limit == '1 && !seg_expdn && seg_big));

  a_r6_flag_strobes: assert property (@(posedge clk) disable iff (rst)
    (clr_vm || clr_if) |-> (clr_vm && clr_if && done && new_cpl == 2'd0));
endmodule

bind fastcall_xfer_unit fastcall_xfer_chk #(
  .XLEN(XLEN), .SEL_W(SEL_W), .STACK_STEP(STACK_STEP)
) u_chk (
  .clk(clk), .rst(rst), .cur_cpl(cur_cpl), .req_enter(req_enter), .req_exit(req_exit),
  .done(done), .fault(fault), .new_eip(new_eip), .new_esp(new_esp),
  .new_cs(new_cs), .new_ss(new_ss), .seg_base(seg_base), .seg_limit(seg_limit),
  .seg_expdn(seg_expdn), .seg_big(seg_big), .new_cpl(new_cpl),
  .clr_vm(clr_vm), .clr_if(clr_if)
);

// File: tb/test_fastcall_xfer_unit.sv
module test_fastcall_xfer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        feat_en = 1'b0, prot_mode = 1'b0;
  logic [1:0]  cur_cpl = 2'd0;
  logic        msr_we = 1'b0;
  logic [1:0]  msr_idx = 2'd0;
  logic [31:0] msr_wdata = '0;
  logic        req_enter = 1'b0, req_exit = 1'b0;
  logic [31:0] gpr_edx = '0, gpr_ecx = '0;
  logic        done, fault, seg_expdn, seg_big, clr_vm, clr_if;
  logic [31:0] new_eip, new_esp, seg_base, seg_limit;
  logic [15:0] new_cs, new_ss;
  logic [1:0]  new_cpl;

  always #2.5 clk = ~clk;

  fastcall_xfer_unit i_fastcall_xfer_unit (
    .clk(clk), .rst(rst), .feat_en(feat_en), .prot_mode(prot_mode), .cur_cpl(cur_cpl),
    .msr_we(msr_we), .msr_idx(msr_idx), .msr_wdata(msr_wdata),
    .req_enter(req_enter), .req_exit(req_exit), .gpr_edx(gpr_edx), .gpr_ecx(gpr_ecx),
    .done(done), .fault(fault), .new_eip(new_eip), .new_esp(new_esp),
    .new_cs(new_cs), .new_ss(new_ss), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_expdn(seg_expdn), .seg_big(seg_big), .new_cpl(new_cpl),
    .clr_vm(clr_vm), .clr_if(clr_if)
  );

  typedef struct {
    bit          ok;
    bit          clr;
    logic [31:0] eip, esp;
    logic [15:0] cs, ss;
    logic [1:0]  cpl;
    bit          flat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  // bench-side model of programmed registers and current outputs
  logic [15:0] m_sel = '0;
  logic [31:0] m_kip = '0, m_ksp = '0;
  logic [31:0] o_eip = '0, o_esp = '0;
  logic [15:0] o_cs = '0, o_ss = '0;
  logic [1:0]  o_cpl = '0;
  bit          o_flat = 0;

  task automatic fail_msg(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic msr_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    msr_we = 1'b1; msr_idx = idx; msr_wdata = d;
    @(posedge clk); #1;
    msr_we = 1'b0;
    case (idx)
      2'd0: m_sel = d[15:0];
      2'd1: m_kip = d;
      2'd2: m_ksp = d;
      default: ;
    endcase
  endtask

  task automatic do_req(input bit en, input bit ex, input bit fe, input bit pm,
                        input logic [1:0] cpl, input logic [31:0] edx,
                        input logic [31:0] ecx, input string tag);
    exp_t e;
    bit ok;
    @(negedge clk);
    feat_en = fe; prot_mode = pm; cur_cpl = cpl; gpr_edx = edx; gpr_ecx = ecx;
    req_enter = en; req_exit = ex;
    ok = fe && pm && (m_sel != 16'h0) && (en != ex) && (en || cpl == 2'd0);
    if (ok && en) begin
      o_eip = m_kip; o_esp = m_ksp; o_cs = {m_sel[15:2], 2'b00}; o_cpl = 2'd0;
    end else if (ok) begin
      o_eip = edx; o_esp = ecx; o_cs = {m_sel[15:2], 2'b11}; o_cpl = 2'd3;
    end
    if (ok) begin
      o_ss = o_cs + 16'd8; o_flat = 1;
    end
    e.ok = ok; e.clr = ok && en; e.eip = o_eip; e.esp = o_esp;
    e.cs = o_cs; e.ss = o_ss; e.cpl = o_cpl; e.flat = o_flat; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
    @(negedge clk);
    req_enter = 1'b0; req_exit = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done || fault) begin
          if (q.size() == 0) begin
            n_run++;
            fail_msg("R11", "unexpected done/fault", {30'd0, done, fault}, 32'd0);
          end else begin
            exp_t e;
            int f0;
            e = q.pop_front();
            n_run++;
            f0 = n_fail;
            if (done != e.ok)   fail_msg(e.tag, "done", 32'(done), 32'(e.ok));
            if (fault != !e.ok) fail_msg(e.tag, "fault", 32'(fault), 32'(!e.ok));
            if (clr_vm != e.clr || clr_if != e.clr)
              fail_msg(e.tag, "clr_vm/clr_if", {30'd0, clr_vm, clr_if}, {30'd0, e.clr, e.clr});
            if (new_eip != e.eip) fail_msg(e.tag, "new_eip", new_eip, e.eip);
            if (new_esp != e.esp) fail_msg(e.tag, "new_esp", new_esp, e.esp);
            if (new_cs != e.cs)   fail_msg(e.tag, "new_cs", 32'(new_cs), 32'(e.cs));
            if (new_ss != e.ss)   fail_msg(e.tag, "new_ss", 32'(new_ss), 32'(e.ss));
            if (new_cpl != e.cpl) fail_msg(e.tag, "new_cpl", 32'(new_cpl), 32'(e.cpl));
            if (e.flat && (seg_base != 0 || seg_limit != 32'hFFFF_FFFF || seg_expdn || !seg_big))
              fail_msg({e.tag, " R9"}, "descriptor limit", seg_limit, 32'hFFFF_FFFF);
            if (n_fail > f0 + 1) n_fail = f0 + 1;
          end
        end else if (clr_vm || clr_if) begin
          n_run++;
          fail_msg("R6", "stray flag strobe", {30'd0, clr_vm, clr_if}, 32'd0);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    fail_msg("WDOG", "watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_run++;
    if (done || fault || clr_vm || clr_if || new_eip != 0 || new_cs != 0 || new_cpl != 0 || seg_limit != 0)
      fail_msg("R1", "reset outputs", {new_cs, 14'd0, done, fault}, 32'd0);
    // R1/R3: selector is zero after reset
    do_req(1, 0, 1, 1, 2'd0, '0, '0, "R1 zero-sel entry");
    do_req(0, 1, 1, 1, 2'd0, '0, '0, "R3 zero-sel exit");
    // R2: program registers, including a spare-index write and wide selector data
    msr_write(2'd0, 32'hABCD_0013);
    msr_write(2'd1, 32'h8000_1000);
    msr_write(2'd2, 32'h9000_0FF0);
    msr_write(2'd3, 32'hDEAD_BEEF);
    // R3: feature disabled, not protected mode
    do_req(1, 0, 0, 1, 2'd0, '0, '0, "R3 feat off");
    do_req(0, 1, 1, 0, 2'd0, '0, '0, "R3 real mode");
    // R6 R7 R9 R10 R2: successful entry
    do_req(1, 0, 1, 1, 2'd3, '0, '0, "R6 R7 R2 entry");
    // R4: exit from ring 3 rejected, state held
    do_req(0, 1, 1, 1, 2'd3, 32'h1111_1111, 32'h2222_2222, "R4 exit cpl3");
    // R8 R10: successful exit
    do_req(0, 1, 1, 1, 2'd0, 32'h1234_5678, 32'h0BAD_F00C, "R8 exit");
    // R5: simultaneous requests
    do_req(1, 1, 1, 1, 2'd0, '0, '0, "R5 both");
    // R2: spare index write had no effect; redo entry
    do_req(1, 0, 1, 1, 2'd0, '0, '0, "R2 spare idx ignored");
    // R7 R8: selector wrap
    msr_write(2'd0, 32'h0000_FFFC);
    do_req(1, 0, 1, 1, 2'd1, '0, '0, "R7 wrap entry");
    do_req(0, 1, 1, 1, 2'd0, 32'hCAFE_0000, 32'h0000_BEEF, "R8 wrap exit");
    do_req(0, 1, 1, 1, 2'd2, '0, '0, "R4 exit cpl2");
    msr_write(2'd1, 32'h0040_0000);
    msr_write(2'd2, 32'h0050_0000);
    do_req(1, 0, 1, 1, 2'd3, '0, '0, "R6 new kernel ptrs");
    repeat (4) @(negedge clk);
    n_run++;
    if (q.size() != 0) fail_msg("R11", "missing responses", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule